// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block behaves like a small serial NOR flash seen from an SPI host. It is a mode-0 slave: the host drives `mosi` while `sclk` is low and samples `miso` on the rising edge. Bytes travel most significant bit first. The first byte after chip select falls is taken as a command code. Later bytes in the same frame are the command's address, its data, or filler that clocks out a response. The byte array is held inside the block. Its size and its erase and program granularities are parameters.

The supported commands are identification, status, write enable, page program, streaming read, and three erase sizes: a large sector, a small sub-sector and the whole array. The sequential logic runs on a system clock `clk`. `sclk`, `cs_n` and `mosi` are brought into that clock domain through synchronizer stages, so `clk` must run several times faster than `sclk`. An erase starts when chip select is released and clears one byte per system clock. The host polls the status byte to see when the erase has finished.

Each response byte is placed on `miso` in the byte slot that follows the byte which asked for it. For example, the first identification byte comes out while the host sends the byte after the command code.

Top module: `nor_flash_responder`

## Requirements
- R1: While `cs_n` is high, `miso` is 1. The byte returned during the command slot of every frame is 0xFF.
- R2: Command 0x9F returns three bytes in the next three slots: MFR_CODE, then TYPE_CODE, then a capacity code equal to log2(MEM_BYTES). Every later slot in that frame returns 0xFF.
- R3: Command 0x05 returns a status byte in every following slot of the frame. Bit 0 is set while an erase is running. Bit 1 is the write-enable latch. Bits 7..2 are zero.
- R4: Command 0x06 sets the write-enable latch, and the latch stays set after the frame ends. If any further byte is clocked in within that same frame, the latch is cleared.
- R5: When a frame that is not a write-enable frame ends, and no erase is running or starting, the write-enable latch is cleared.
- R6: Command 0x03 is followed by a three-byte address, most significant byte first. It then returns consecutive array bytes, starting at that address, in every following slot. Only the low log2(MEM_BYTES) address bits select a byte, so after the last byte of the array the read continues at byte 0.
- R7: Command 0x02 is followed by a three-byte address. Each later data byte is stored at the current address. The address then advances modulo PAGE_BYTES inside its aligned page, so that bytes past the end of the page overwrite bytes at the start of that page.
- R8: Program and erase commands change no array byte unless the write-enable latch is set.
- R9: Commands 0xD8 and 0x20 take a three-byte address. When chip select rises, they set to 0xFF the aligned region of SECTOR_BYTES (for 0xD8) or SUBSECTOR_BYTES (for 0x20) that contains that address. A frame that ends before the third address byte erases nothing.
- R10: Command 0xC7 sets every array byte to 0xFF once chip select rises.
- R11: While an erase runs, the status byte reads 0x03. New erase and program commands are not acted on. When the erase completes, the status byte returns to 0x00, because the write-enable latch clears at completion.
- R12: A command code that is not listed here makes every remaining slot of the frame return 0xFF. The rest of that frame has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all sequential logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, changes after falling `sclk` |

## Verification
The bench builds the block with a 256-byte array, 64-byte sectors, 16-byte sub-sectors and 8-byte pages, which gives an identification capacity code of 0x08. At this size the bench can read the whole array back through the serial port and compare every byte with its own model, after a bulk erase and again after a sweep that programs every page. Erasing 256 bytes takes about as long as two serial bytes, so a status frame sent right after a bulk erase shows the busy value in two slots and the idle value in the third. Page wrap, the read running past the last array byte, and the alignment of both erase sizes all fall on exact byte offsets that can be predicted and checked in a space this small.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

  // Command codes decoded from the first byte of a frame
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SECT = 8'hD8;
  localparam logic [7:0] OP_SUBS = 8'h20;
  localparam logic [7:0] OP_BULK = 8'hC7;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] FILL    = 8'hFF;

  typedef enum logic [3:0] {
    ST_OPC, ST_ID0, ST_ID1, ST_STAT, ST_WEN,
    ST_ADR0, ST_ADR1, ST_ADR2, ST_PROG, ST_READ, ST_SKIP
  } cmd_st_t;

  typedef enum logic [1:0] {ER_SECT, ER_SUB, ER_BULK} erase_kind_t;

  // Next program address: advance inside the aligned page only
  function automatic logic [23:0] page_step(input logic [23:0] a, input int unsigned page);
    logic [23:0] m;
    m = 24'(page - 1);
    return (a & ~m) | ((a + 24'd1) & m);
  endfunction

  // Capacity code in the identification reply is log2 of the array size
  function automatic logic [7:0] capacity_code(input int unsigned bytes);
    return 8'($clog2(bytes));
  endfunction

  function automatic logic [7:0] status_byte(input logic latch, input logic wip);
    return {6'b0, latch, wip};
  endfunction

endpackage

// File: rtl/nfr_sync.sv
module nfr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_idle,
  output logic mosi_s
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0]          sclk_p;
  logic [PW-1:0]          cs_p;
  logic [SYNC_STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '1;
    end else begin
      sclk_p <= {sclk_p[PW-2:0], sclk};
      cs_p   <= {cs_p[PW-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_p[PW-2] & ~sclk_p[PW-1];
  assign sclk_fall = ~sclk_p[PW-2] & sclk_p[PW-1];
  assign cs_rise   = cs_p[PW-2] & ~cs_p[PW-1];
  assign cs_idle   = cs_p[PW-2];
  assign mosi_s    = mosi_p[SYNC_STAGES-1];

endmodule

// File: rtl/nfr_shifter.sv
module nfr_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       cs_idle,
  input  logic       mosi_s,
  input  logic [7:0] resp,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic       load_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_q      <= '0;
      tx_q      <= 8'hFF;
      load_pend <= 1'b0;
    end else if (cs_idle) begin
      bit_cnt   <= '0;
      tx_q      <= 8'hFF;
      load_pend <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_q    <= {rx_q[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) load_pend <= 1'b1;
      end
      if (sclk_fall) begin
        if (load_pend) begin
          tx_q      <= resp;   // response enters the slot after its request
          load_pend <= 1'b0;
        end else begin
          tx_q <= {tx_q[6:0], 1'b1};
        end
      end
    end
  end

  assign byte_done = !cs_idle && sclk_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_q, mosi_s};
  assign miso      = cs_idle ? 1'b1 : tx_q[7];

endmodule

// File: rtl/nfr_cmd_fsm.sv
module nfr_cmd_fsm
  import nfr_pkg::*;
#(
  parameter int          MEM_BYTES  = 2048,
  parameter int          PAGE_BYTES = 32,
  parameter logic [7:0]  MFR_CODE   = 8'h20,
  parameter logic [7:0]  TYPE_CODE  = 8'h20,
  localparam int         AW         = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic          cs_rise,
  input  logic          busy,
  input  logic          erase_done,
  input  logic [7:0]    rd_data,
  output logic [7:0]    resp,
  output logic          wel,
  output logic [AW-1:0] rd_idx,
  output logic          prog_we,
  output logic [AW-1:0] prog_idx,
  output logic [7:0]    prog_data,
  output logic          erase_start,
  output erase_kind_t   erase_kind,
  output logic [AW-1:0] erase_addr
);
  localparam logic [7:0] CAP_CODE = capacity_code(MEM_BYTES);

  cmd_st_t     st;
  logic [7:0]  op_q;
  logic [23:0] addr_q;
  logic        arm_q;
  erase_kind_t kind_q;
  logic [23:0] full_addr;

  assign full_addr   = {addr_q[23:8], rx_byte};
  assign rd_idx      = (st == ST_ADR2) ? full_addr[AW-1:0] : addr_q[AW-1:0];
  assign prog_we     = byte_done && (st == ST_PROG) && wel && !busy;
  assign prog_idx    = addr_q[AW-1:0];
  assign prog_data   = rx_byte;
  assign erase_start = cs_rise && arm_q && wel && !busy;
  assign erase_kind  = kind_q;
  assign erase_addr  = addr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OPC;
      op_q   <= FILL;
      addr_q <= '0;
      arm_q  <= 1'b0;
      kind_q <= ER_BULK;
      wel    <= 1'b0;
      resp   <= FILL;
    end else begin
      if (erase_done) wel <= 1'b0;
      if (cs_rise) begin
        st    <= ST_OPC;
        op_q  <= FILL;
        arm_q <= 1'b0;
        resp  <= FILL;
        if (!busy && !erase_start && op_q != OP_WREN) wel <= 1'b0;
      end else if (byte_done) begin
        resp <= FILL;
        case (st)
          ST_OPC: begin
            op_q <= rx_byte;
            case (rx_byte)
              OP_RDID: begin resp <= MFR_CODE; st <= ST_ID0; end
              OP_RDSR: begin resp <= status_byte(wel, busy); st <= ST_STAT; end
              OP_WREN: begin wel <= 1'b1; st <= ST_WEN; end
              OP_BULK: begin
                st <= ST_SKIP;
                if (wel && !busy) begin arm_q <= 1'b1; kind_q <= ER_BULK; end
              end
              OP_SECT, OP_SUBS, OP_PROG, OP_READ: st <= ST_ADR0;
              default: st <= ST_SKIP;
            endcase
          end
          ST_ID0:  begin resp <= TYPE_CODE; st <= ST_ID1; end
          ST_ID1:  begin resp <= CAP_CODE;  st <= ST_SKIP; end
          ST_STAT: resp <= status_byte(wel, busy);
          ST_WEN:  wel <= 1'b0;   // extra byte cancels the latch
          ST_ADR0: begin addr_q <= {rx_byte, 16'h0000}; st <= ST_ADR1; end
          ST_ADR1: begin addr_q[15:8] <= rx_byte; st <= ST_ADR2; end
          ST_ADR2: begin
            case (op_q)
              OP_READ: begin
                resp   <= rd_data;
                addr_q <= full_addr + 24'd1;
                st     <= ST_READ;
              end
              OP_PROG: begin
                addr_q <= full_addr;
                st     <= ST_PROG;
              end
              default: begin
                addr_q <= full_addr;
                st     <= ST_SKIP;
                if (wel && !busy) begin
                  arm_q  <= 1'b1;
                  kind_q <= (op_q == OP_SECT) ? ER_SECT : ER_SUB;
                end
              end
            endcase
          end
          ST_READ: begin resp <= rd_data; addr_q <= addr_q + 24'd1; end
          ST_PROG: addr_q <= page_step(addr_q, PAGE_BYTES);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nfr_store.sv
module nfr_store
  import nfr_pkg::*;
#(
  parameter int  MEM_BYTES       = 2048,
  parameter int  SECTOR_BYTES    = 512,
  parameter int  SUBSECTOR_BYTES = 128,
  localparam int AW              = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_idx,
  input  logic [7:0]    prog_data,
  input  logic          erase_start,
  input  erase_kind_t   erase_kind,
  input  logic [AW-1:0] erase_addr,
  output logic          busy,
  output logic          erase_done
);
  logic [7:0]    mem [MEM_BYTES];
  logic [AW-1:0] ptr_q, last_q;
  logic [AW-1:0] span_m1, base;

  function automatic logic [AW-1:0] align_down(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return a & ~m;
  endfunction

  always_comb begin
    case (erase_kind)
      ER_SECT: span_m1 = AW'(SECTOR_BYTES - 1);
      ER_SUB:  span_m1 = AW'(SUBSECTOR_BYTES - 1);
      default: span_m1 = AW'(MEM_BYTES - 1);
    endcase
    base = align_down(erase_addr, span_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (erase_start) begin
      busy   <= 1'b1;
      ptr_q  <= base;
      last_q <= base | span_m1;
    end else if (busy) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == last_q) busy <= 1'b0;
    end
  end

  assign erase_done = busy && (ptr_q == last_q);

  always_ff @(posedge clk) begin
    if (busy)         mem[ptr_q]    <= 8'hFF;
    else if (prog_we) mem[prog_idx] <= prog_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/nor_flash_responder.sv
module nor_flash_responder #(
  parameter int         MEM_BYTES       = 2048,
  parameter int         SECTOR_BYTES    = 512,
  parameter int         SUBSECTOR_BYTES = 128,
  parameter int         PAGE_BYTES      = 32,
  parameter logic [7:0] MFR_CODE        = 8'h20,
  parameter logic [7:0] TYPE_CODE       = 8'h20,
  parameter int         SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  import nfr_pkg::*;
  localparam int AW = $clog2(MEM_BYTES);

  logic          sclk_rise, sclk_fall, cs_rise, cs_idle, mosi_s;
  logic          byte_done;
  logic [7:0]    rx_byte, resp, rd_data, prog_data;
  logic          wel, prog_we, erase_start, erase_busy, erase_done;
  logic [AW-1:0] rd_idx, prog_idx, erase_addr;
  erase_kind_t   erase_kind;

  nfr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  nfr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .mosi_s(mosi_s), .resp(resp),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
  );

  nfr_cmd_fsm #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .MFR_CODE(MFR_CODE), .TYPE_CODE(TYPE_CODE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_rise(cs_rise), .busy(erase_busy), .erase_done(erase_done),
    .rd_data(rd_data), .resp(resp), .wel(wel), .rd_idx(rd_idx),
    .prog_we(prog_we), .prog_idx(prog_idx), .prog_data(prog_data),
    .erase_start(erase_start), .erase_kind(erase_kind), .erase_addr(erase_addr)
  );

  nfr_store #(
    .MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .SUBSECTOR_BYTES(SUBSECTOR_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .prog_we(prog_we), .prog_idx(prog_idx), .prog_data(prog_data),
    .erase_start(erase_start), .erase_kind(erase_kind), .erase_addr(erase_addr),
    .busy(erase_busy), .erase_done(erase_done)
  );

endmodule

// File: rtl/nfr_checker.sv
module nfr_checker (
  input logic clk,
  input logic rst_n,
  input logic miso,
  input logic cs_idle,
  input logic cs_rise,
  input logic busy,
  input logic wel,
  input logic prog_we,
  input logic erase_start
);

  // R1
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> miso);

  // R8
  prog_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> wel);

  // R8
  erase_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> wel);

  // R11
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> !busy);

  // R11
  erase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !busy);

  // R9
  erase_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

endmodule

bind nor_flash_responder nfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .cs_idle(cs_idle), .cs_rise(cs_rise),
  .busy(erase_busy), .wel(wel), .prog_we(prog_we), .erase_start(erase_start)
);

// File: tb/sim_nor_flash_responder.sv
module sim_nor_flash_responder;
  localparam int MEMB = 256;
  localparam int SECT = 64;
  localparam int SUBS = 16;
  localparam int PAGE = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b1;
  logic miso;

  always #2 clk = ~clk;

  nor_flash_responder #(
    .MEM_BYTES(MEMB), .SECTOR_BYTES(SECT), .SUBSECTOR_BYTES(SUBS), .PAGE_BYTES(PAGE)
  ) u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [MEMB];
  logic [7:0] rsp [300];
  int nrsp = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    rsp[nrsp] = r;
    nrsp++;
  endtask

  task automatic open_frame();
    nrsp = 0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_addr(input logic [7:0] op, input logic [23:0] a);
    xfer(op); xfer(a[23:16]); xfer(a[15:8]); xfer(a[7:0]);
  endtask

  task automatic wren();
    open_frame(); xfer(8'h06); close_frame();
  endtask

  task automatic read_block(input logic [23:0] a, input int n);
    open_frame();
    send_addr(8'h03, a);
    for (int i = 0; i < n; i++) xfer(8'h00);
    close_frame();
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    open_frame(); xfer(8'h05); xfer(8'h00); close_frame();
    check(tag, rsp[1], exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 miso idle after reset", miso, 1'b1);

    // R2 identification, with R1 filler in the command slot
    open_frame();
    xfer(8'h9F); for (int i = 0; i < 4; i++) xfer(8'h00);
    close_frame();
    check("R1 command slot filler", rsp[0], 8'hFF);
    check("R2 manufacturer code", rsp[1], 8'h20);
    check("R2 type code", rsp[2], 8'h20);
    check("R2 capacity code", rsp[3], 8'($clog2(MEMB)));
    check("R2 trailing filler", rsp[4], 8'hFF);

    // R3 status when idle, repeated in every slot
    open_frame(); xfer(8'h05); xfer(8'h00); xfer(8'h00); close_frame();
    check("R3 status slot1", rsp[1], 8'h00);
    check("R3 status slot2", rsp[2], 8'h00);

    // R4 latch persists, R5 cleared after another frame
    wren();
    status_is("R4 latch set after frame", 8'h02);
    status_is("R5 latch cleared by status frame", 8'h00);
    open_frame(); xfer(8'h06); xfer(8'h00); close_frame();
    status_is("R4 extra byte cancels latch", 8'h00);

    // R10 bulk erase, R11 busy visible in status
    wren();
    open_frame(); xfer(8'hC7); close_frame();
    open_frame(); xfer(8'h05); for (int i = 0; i < 3; i++) xfer(8'h00); close_frame();
    check("R11 status busy slot1", rsp[1], 8'h03);
    check("R11 status busy slot2", rsp[2], 8'h03);
    check("R11 status after completion", rsp[3], 8'h00);
    repeat (300) @(negedge clk);
    for (int a = 0; a < MEMB; a++) model[a] = 8'hFF;
    read_block(24'h000000, MEMB);
    for (int a = 0; a < MEMB; a++) check("R10 bulk erased byte", rsp[4 + a], 8'hFF);

    // R8 program without latch
    open_frame(); send_addr(8'h02, 24'h000010); xfer(8'h55); close_frame();
    read_block(24'h000010, 1);
    check("R8 program ignored without latch", rsp[4], 8'hFF);

    // R7 program every page; upper address byte beyond the array is ignored (R6)
    for (int p = 0; p < MEMB / PAGE; p++) begin
      wren();
      open_frame();
      send_addr(8'h02, {8'h05, 8'h00, 8'(p * PAGE)});
      for (int i = 0; i < PAGE; i++) begin
        xfer(pat(p * PAGE + i));
        model[p * PAGE + i] = pat(p * PAGE + i);
      end
      close_frame();
    end

    // R7 page wrap: start at offset 5 of page 3, ten bytes
    wren();
    open_frame();
    send_addr(8'h02, 24'(3 * PAGE + 5));
    for (int i = 0; i < 10; i++) begin
      xfer(8'hA0 + 8'(i));
      model[3 * PAGE + ((5 + i) % PAGE)] = 8'hA0 + 8'(i);
    end
    close_frame();
    read_block(24'(3 * PAGE), PAGE);
    for (int i = 0; i < PAGE; i++) check("R7 page wrap byte", rsp[4 + i], model[3 * PAGE + i]);

    // R6 read runs past the last byte back to zero
    read_block(24'(MEMB - 2), 4);
    check("R6 read at end-2", rsp[4], model[MEMB - 2]);
    check("R6 read at end-1", rsp[5], model[MEMB - 1]);
    check("R6 read wraps to 0", rsp[6], model[0]);
    check("R6 read wraps to 1", rsp[7], model[1]);

    // R12 unknown code followed by what would be a program
    wren();
    open_frame();
    xfer(8'hAB); send_addr(8'h02, 24'h000000); xfer(8'h77);
    close_frame();
    for (int i = 0; i < 6; i++) check("R12 unknown code filler", rsp[i], 8'hFF);
    status_is("R5 latch cleared by unknown frame", 8'h00);

    // R9 sector and sub-sector erase
    wren();
    open_frame(); send_addr(8'hD8, 24'h000045); close_frame();
    repeat (300) @(negedge clk);
    for (int a = 0; a < MEMB; a++) if ((a & ~(SECT - 1)) == 'h40) model[a] = 8'hFF;
    status_is("R11 latch clear after erase", 8'h00);
    wren();
    open_frame(); send_addr(8'h20, 24'h0000A5); close_frame();
    repeat (300) @(negedge clk);
    for (int a = 0; a < MEMB; a++) if ((a & ~(SUBS - 1)) == 'hA0) model[a] = 8'hFF;

    // R8 erase without latch, R9 short frame erases nothing
    open_frame(); send_addr(8'hD8, 24'h0000C5); close_frame();
    repeat (300) @(negedge clk);
    wren();
    open_frame(); xfer(8'h20); xfer(8'h00); xfer(8'h00); close_frame();
    repeat (100) @(negedge clk);

    read_block(24'h000000, MEMB);
    for (int a = 0; a < MEMB; a++) begin
      if (a >= 'h40 && a < 'h80)      check("R9 sector region", rsp[4 + a], model[a]);
      else if (a >= 'hA0 && a < 'hB0) check("R9 sub-sector region", rsp[4 + a], model[a]);
      else if (a >= 'hC0)             check("R8 unlatched erase kept data", rsp[4 + a], model[a]);
      else                            check("R7 programmed data", rsp[4 + a], model[a]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule